// File: doc/BRIEF.md
# Big-Endian Load/Store Lane Aligner

This block is the datapath stage between a processor core and a big-endian external data bus. For loads it takes the raw bus word, the low address bits and a transfer kind. It picks the addressed byte or halfword lane, moves it to the bottom of the result and fills the upper bits with zeros or with copies of the sign bit. A full word passes through unchanged. The result and a misalignment flag are captured in a register when the core strobes a load.

For halfword stores the block copies the low halfword of the source register into both halves of the write word. It also drives byte-enable lanes that tell the memory system which half to write, and flags a store address that is not halfword aligned. Address generation, bus timing, abort handling and register writeback belong to neighbouring blocks.

Top module: `be_lane_aligner`

## Requirements
- R1: For a signed byte load (`ld_type` = 2'b00), address offset 0 selects bus bits 31:24, offset 1 bits 23:16, offset 2 bits 15:8 and offset 3 bits 7:0. The selected byte lands in result bits 7:0.
- R2: For a signed byte load, result bits 31:8 are copies of bit 7 of the selected byte.
- R3: For a halfword load (`ld_type` 2'b01 or 2'b10), `ld_addr_lo[1]` = 0 selects bus bits 31:16 and `ld_addr_lo[1]` = 1 selects bus bits 15:0. The selected halfword lands in result bits 15:0.
- R4: An unsigned halfword load (`ld_type` = 2'b01) clears result bits 31:16.
- R5: A signed halfword load (`ld_type` = 2'b10) fills result bits 31:16 with bit 15 of the selected halfword.
- R6: A word load (`ld_type` = 2'b11) returns the bus word unchanged, whatever the address bits.
- R7: `st_wdata` carries `st_half` in bits 31:16 and again in bits 15:0.
- R8: `st_byte_en` is 4'b1100 when `st_addr_lo[1]` = 0 and 4'b0011 when `st_addr_lo[1]` = 1. Bit 3 stands for bus bits 31:24.
- R9: A halfword load with `ld_addr_lo[0]` = 1 sets `ld_misalign` on the capturing edge, and `st_misalign` follows `st_addr_lo[0]` combinationally.
- R10: `ld_misalign` is captured low for byte and word loads at every address.
- R11: `ld_result` and `ld_misalign` change only on a rising edge with `ld_valid` high. Otherwise they hold.
- R12: A synchronous active-high `rst` clears `ld_result` and `ld_misalign` on the next rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| ld_valid | input | 1 | Load capture strobe |
| ld_type | input | 2 | Load kind: 00 signed byte, 01 unsigned half, 10 signed half, 11 word |
| ld_addr_lo | input | 2 | Low address bits of the load |
| bus_rdata | input | 32 | Raw word read from the bus |
| ld_result | output | 32 | Registered, aligned and extended load value |
| ld_misalign | output | 1 | Registered misaligned-halfword-load flag |
| st_half | input | 16 | Low halfword of the store source register |
| st_addr_lo | input | 2 | Low address bits of the store |
| st_wdata | output | 32 | Replicated store word for the bus |
| st_byte_en | output | 4 | Active byte lanes, bit 3 = bus bits 31:24 |
| st_misalign | output | 1 | Store address not halfword aligned |

## Verification
The bound checker checks several properties on every cycle, for any values that occur:
- store replication and the byte-enable pattern;
- sign fill after a byte load and zero fill after an unsigned halfword load;
- misalignment capture for halfword loads and the absence of a flag for byte loads;
- the result holding while no load is strobed;
- clearing on reset.

Which lane is picked for each address offset, and the exact extended values, can only be shown by the bench's directed scenarios. The bench compares those against fixed patterns chosen so that every lane, and both sign states, give a distinct result.

// File: rtl/be_align_pkg.sv
package be_align_pkg;
   typedef enum logic [1:0] {
      XF_SBYTE = 2'b00,
      XF_UHALF = 2'b01,
      XF_SHALF = 2'b10,
      XF_WORD  = 2'b11
   } xfer_e;
endpackage

// File: rtl/be_lane_pick.sv
// Splits a bus word into byte and halfword lanes and selects the addressed ones.
module be_lane_pick #(
   parameter int BUS_W   = 32,
   parameter int LANE_W  = 8,
   parameter bit BIG_END = 1'b1,
   parameter int AW      = $clog2(BUS_W / LANE_W)
) (
   input  logic [BUS_W-1:0]    word,
   input  logic [AW-1:0]       offs,
   output logic [LANE_W-1:0]   byte_q,
   output logic [2*LANE_W-1:0] half_q
);
   localparam int LANES  = BUS_W / LANE_W;
   localparam int HALVES = LANES / 2;
   localparam int HW     = 2 * LANE_W;

   logic [LANE_W-1:0] lane  [LANES];
   logic [HW-1:0]     hlane [HALVES];

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      if (BIG_END) begin : g_be
         assign lane[i] = word[BUS_W-1-i*LANE_W -: LANE_W];
      end else begin : g_le
         assign lane[i] = word[i*LANE_W +: LANE_W];
      end
   end

   for (genvar j = 0; j < HALVES; j++) begin : g_half
      if (BIG_END) begin : g_be
         assign hlane[j] = word[BUS_W-1-j*HW -: HW];
      end else begin : g_le
         assign hlane[j] = word[j*HW +: HW];
      end
   end

   assign byte_q = lane[offs];
   assign half_q = hlane[offs[AW-1:1]];
endmodule

// File: rtl/be_fill_extend.sv
// Right-justifies the selected lane and fills the upper bits.
module be_fill_extend
   import be_align_pkg::*;
#(
   parameter int BUS_W  = 32,
   parameter int LANE_W = 8
) (
   input  xfer_e               kind,
   input  logic [LANE_W-1:0]   byte_in,
   input  logic [2*LANE_W-1:0] half_in,
   input  logic [BUS_W-1:0]    word_in,
   output logic [BUS_W-1:0]    res
);
   localparam int HW = 2 * LANE_W;

   always_comb begin
      unique case (kind)
         XF_SBYTE: res = {{(BUS_W-LANE_W){byte_in[LANE_W-1]}}, byte_in};
         XF_UHALF: res = {{(BUS_W-HW){1'b0}}, half_in};
         XF_SHALF: res = {{(BUS_W-HW){half_in[HW-1]}}, half_in};
         default:  res = word_in;
      endcase
   end
endmodule

// File: rtl/be_store_repl.sv
// Replicates a halfword across the bus and drives the byte enables.
module be_store_repl #(
   parameter int BUS_W   = 32,
   parameter int LANE_W  = 8,
   parameter bit BIG_END = 1'b1,
   parameter int AW      = $clog2(BUS_W / LANE_W)
) (
   input  logic [2*LANE_W-1:0]       src_half,
   input  logic [AW-1:0]             offs,
   output logic [BUS_W-1:0]          wdata,
   output logic [BUS_W/LANE_W-1:0]   ben
);
   localparam int LANES  = BUS_W / LANE_W;
   localparam int HALVES = LANES / 2;
   localparam int HW     = 2 * LANE_W;

   for (genvar h = 0; h < HALVES; h++) begin : g_rep
      assign wdata[h*HW +: HW] = src_half;
   end

   always_comb begin
      ben = '0;
      for (int h = 0; h < HALVES; h++) begin
         if (int'(offs[AW-1:1]) == h) begin
            if (BIG_END) begin
               ben[LANES-1-2*h] = 1'b1;
               ben[LANES-2-2*h] = 1'b1;
            end else begin
               ben[2*h]   = 1'b1;
               ben[2*h+1] = 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/be_lane_aligner.sv
module be_lane_aligner
   import be_align_pkg::*;
#(
   parameter int BUS_W   = 32,
   parameter int LANE_W  = 8,
   parameter bit BIG_END = 1'b1
) (
   input  logic                      clk,
   input  logic                      rst,
   input  logic                      ld_valid,
   input  logic [1:0]                ld_type,
   input  logic [$clog2(BUS_W/LANE_W)-1:0] ld_addr_lo,
   input  logic [BUS_W-1:0]          bus_rdata,
   output logic [BUS_W-1:0]          ld_result,
   output logic                      ld_misalign,
   input  logic [2*LANE_W-1:0]       st_half,
   input  logic [$clog2(BUS_W/LANE_W)-1:0] st_addr_lo,
   output logic [BUS_W-1:0]          st_wdata,
   output logic [BUS_W/LANE_W-1:0]   st_byte_en,
   output logic                      st_misalign
);
   localparam int LANES = BUS_W / LANE_W;
   localparam int AW    = $clog2(LANES);

   if (LANE_W < 1) begin : g_bad_lane
      $error("LANE_W must be positive");
   end
   if (BUS_W % (2 * LANE_W) != 0) begin : g_bad_bus
      $error("BUS_W must hold a whole number of halfwords");
   end
   if ((1 << AW) != LANES || LANES < 2) begin : g_bad_pow
      $error("lane count must be a power of two, at least 2");
   end

   xfer_e               kind;
   logic [LANE_W-1:0]   byte_sel;
   logic [2*LANE_W-1:0] half_sel;
   logic [BUS_W-1:0]    res_d;
   logic                mis_d;
   logic [BUS_W-1:0]    res_q;
   logic                mis_q;

   assign kind = xfer_e'(ld_type);

   be_lane_pick #(.BUS_W(BUS_W), .LANE_W(LANE_W), .BIG_END(BIG_END), .AW(AW)) u_pick (
      .word   (bus_rdata),
      .offs   (ld_addr_lo),
      .byte_q (byte_sel),
      .half_q (half_sel)
   );

   be_fill_extend #(.BUS_W(BUS_W), .LANE_W(LANE_W)) u_fill (
      .kind    (kind),
      .byte_in (byte_sel),
      .half_in (half_sel),
      .word_in (bus_rdata),
      .res     (res_d)
   );

   assign mis_d = ((kind == XF_UHALF) || (kind == XF_SHALF)) && ld_addr_lo[0];

   always_ff @(posedge clk) begin
      if (rst) begin
         res_q <= '0;
         mis_q <= 1'b0;
      end else if (ld_valid) begin
         res_q <= res_d;
         mis_q <= mis_d;
      end
   end

   assign ld_result   = res_q;
   assign ld_misalign = mis_q;

   be_store_repl #(.BUS_W(BUS_W), .LANE_W(LANE_W), .BIG_END(BIG_END), .AW(AW)) u_store (
      .src_half (st_half),
      .offs     (st_addr_lo),
      .wdata    (st_wdata),
      .ben      (st_byte_en)
   );

   assign st_misalign = st_addr_lo[0];
endmodule

// File: rtl/be_lane_aligner_chk.sv
module be_lane_aligner_chk #(
   parameter int BUS_W  = 32,
   parameter int LANE_W = 8
) (
   input logic                      clk,
   input logic                      rst,
   input logic                      ld_valid,
   input logic [1:0]                ld_type,
   input logic [$clog2(BUS_W/LANE_W)-1:0] ld_addr_lo,
   input logic [BUS_W-1:0]          ld_result,
   input logic                      ld_misalign,
   input logic [2*LANE_W-1:0]       st_half,
   input logic [$clog2(BUS_W/LANE_W)-1:0] st_addr_lo,
   input logic [BUS_W-1:0]          st_wdata,
   input logic [BUS_W/LANE_W-1:0]   st_byte_en,
   input logic                      st_misalign
);
   localparam int HW = 2 * LANE_W;
   localparam int AW = $clog2(BUS_W / LANE_W);

   p_store_repl_r7: assert property (@(posedge clk) disable iff (rst)
      st_wdata[HW-1:0] == st_half && st_wdata[BUS_W-1 -: HW] == st_half);

   p_byte_en_pair_r8: assert property (@(posedge clk) disable iff (rst)
      $countones(st_byte_en) == 2 && (st_byte_en[1] == st_addr_lo[1]));

   p_st_mis_r9: assert property (@(posedge clk) disable iff (rst)
      st_misalign == st_addr_lo[0]);

   p_half_mis_r9: assert property (@(posedge clk) disable iff (rst)
      (ld_valid && ld_type[1] != ld_type[0] && ld_addr_lo[0]) |=> ld_misalign);

   p_byte_nomis_r10: assert property (@(posedge clk) disable iff (rst)
      (ld_valid && ld_type == 2'b00) |=> !ld_misalign);

   p_sbyte_fill_r2: assert property (@(posedge clk) disable iff (rst)
      (ld_valid && ld_type == 2'b00) |=>
         (ld_result[BUS_W-1:LANE_W] == {(BUS_W-LANE_W){ld_result[LANE_W-1]}}));

   p_uhalf_zero_r4: assert property (@(posedge clk) disable iff (rst)
      (ld_valid && ld_type == 2'b01) |=> ld_result[BUS_W-1:HW] == '0);

   p_hold_r11: assert property (@(posedge clk) disable iff (rst)
      !ld_valid |=> ($stable(ld_result) && $stable(ld_misalign)));

   p_rst_clear_r12: assert property (@(posedge clk)
      rst |=> (ld_result == '0 && !ld_misalign));

   initial begin
      a_aw_r1: assert (AW >= 2);
   end
endmodule

bind be_lane_aligner be_lane_aligner_chk #(.BUS_W(BUS_W), .LANE_W(LANE_W)) u_chk (
   .clk         (clk),
   .rst         (rst),
   .ld_valid    (ld_valid),
   .ld_type     (ld_type),
   .ld_addr_lo  (ld_addr_lo),
   .ld_result   (ld_result),
   .ld_misalign (ld_misalign),
   .st_half     (st_half),
   .st_addr_lo  (st_addr_lo),
   .st_wdata    (st_wdata),
   .st_byte_en  (st_byte_en),
   .st_misalign (st_misalign)
);

// File: tb/be_lane_aligner_tb.sv
`timescale 1ns/1ps
module be_lane_aligner_tb;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        ld_valid = 1'b0;
   logic [1:0]  ld_type = 2'b00;
   logic [1:0]  ld_addr_lo = 2'b00;
   logic [31:0] bus_rdata = '0;
   logic [31:0] ld_result;
   logic        ld_misalign;
   logic [15:0] st_half = '0;
   logic [1:0]  st_addr_lo = 2'b00;
   logic [31:0] st_wdata;
   logic [3:0]  st_byte_en;
   logic        st_misalign;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   be_lane_aligner u_dut (
      .clk(clk), .rst(rst), .ld_valid(ld_valid), .ld_type(ld_type),
      .ld_addr_lo(ld_addr_lo), .bus_rdata(bus_rdata), .ld_result(ld_result),
      .ld_misalign(ld_misalign), .st_half(st_half), .st_addr_lo(st_addr_lo),
      .st_wdata(st_wdata), .st_byte_en(st_byte_en), .st_misalign(st_misalign)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // drive one load on a negedge, capture on the posedge, return at the next negedge
   task automatic do_load(input logic [1:0] t, input logic [1:0] a, input logic [31:0] d);
      @(negedge clk);
      ld_type = t; ld_addr_lo = a; bus_rdata = d; ld_valid = 1'b1;
      @(negedge clk);
      ld_valid = 1'b0;
   endtask

   task automatic t_reset();
      chk("R12 reset result", ld_result, 32'h0);
      chk("R12 reset flag", {31'b0, ld_misalign}, 32'h0);
   endtask

   task automatic t_sbyte();
      logic [31:0] exp [4] = '{32'hFFFF_FF80, 32'h0000_007F, 32'hFFFF_FFC3, 32'h0000_0015};
      for (int i = 0; i < 4; i++) begin
         do_load(2'b00, 2'(i), 32'h807F_C315);
         chk($sformatf("R1 R2 sbyte offset %0d", i), ld_result, exp[i]);
         chk("R10 byte no flag", {31'b0, ld_misalign}, 32'h0);
      end
      do_load(2'b00, 2'd3, 32'h0000_0080);
      chk("R2 sbyte lane3 negative", ld_result, 32'hFFFF_FF80);
   endtask

   task automatic t_half();
      do_load(2'b01, 2'd0, 32'h8001_7FFE);
      chk("R3 R4 uhalf upper", ld_result, 32'h0000_8001);
      do_load(2'b01, 2'd2, 32'h7FFE_9003);
      chk("R3 R4 uhalf lower", ld_result, 32'h0000_9003);
      do_load(2'b10, 2'd0, 32'h8001_7FFE);
      chk("R5 shalf upper neg", ld_result, 32'hFFFF_8001);
      do_load(2'b10, 2'd2, 32'h8001_7FFE);
      chk("R5 shalf lower pos", ld_result, 32'h0000_7FFE);
      chk("R9 aligned half no flag", {31'b0, ld_misalign}, 32'h0);
   endtask

   task automatic t_word_misalign();
      do_load(2'b01, 2'd1, 32'h1234_5678);
      chk("R9 uhalf addr1 flag", {31'b0, ld_misalign}, 32'h1);
      do_load(2'b00, 2'd1, 32'h1234_5678);
      chk("R10 byte addr1 no flag", {31'b0, ld_misalign}, 32'h0);
      do_load(2'b10, 2'd3, 32'h1234_5678);
      chk("R9 shalf addr3 flag", {31'b0, ld_misalign}, 32'h1);
      do_load(2'b11, 2'd3, 32'hDEAD_BEEF);
      chk("R6 word passthrough addr3", ld_result, 32'hDEAD_BEEF);
      chk("R10 word no flag", {31'b0, ld_misalign}, 32'h0);
      do_load(2'b11, 2'd1, 32'h0102_0304);
      chk("R6 word passthrough addr1", ld_result, 32'h0102_0304);
   endtask

   task automatic t_hold();
      do_load(2'b10, 2'd1, 32'h8001_0000);
      @(negedge clk);
      ld_type = 2'b11; ld_addr_lo = 2'd0; bus_rdata = 32'h5555_AAAA;
      @(negedge clk);
      @(negedge clk);
      chk("R11 hold result", ld_result, 32'hFFFF_8001);
      chk("R11 hold flag", {31'b0, ld_misalign}, 32'h1);
   endtask

   task automatic t_store();
      @(negedge clk);
      st_half = 16'hA55A; st_addr_lo = 2'd0;
      #1;
      chk("R7 store replicate", st_wdata, 32'hA55A_A55A);
      chk("R8 byte enables addr0", {28'b0, st_byte_en}, 32'hC);
      chk("R9 store aligned", {31'b0, st_misalign}, 32'h0);
      st_half = 16'h0F31; st_addr_lo = 2'd2;
      #1;
      chk("R7 store replicate 2", st_wdata, 32'h0F31_0F31);
      chk("R8 byte enables addr2", {28'b0, st_byte_en}, 32'h3);
      st_addr_lo = 2'd1;
      #1;
      chk("R9 store misaligned", {31'b0, st_misalign}, 32'h1);
      chk("R8 byte enables addr1", {28'b0, st_byte_en}, 32'hC);
   endtask

   task automatic t_reset_mid();
      do_load(2'b01, 2'd3, 32'hFFFF_FFFF);
      @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      chk("R12 mid reset result", ld_result, 32'h0);
      chk("R12 mid reset flag", {31'b0, ld_misalign}, 32'h0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst = 1'b0;
      t_reset();
      t_sbyte();
      t_half();
      t_word_misalign();
      t_hold();
      t_store();
      t_reset_mid();
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #400000;
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule